// File: doc/BRIEF.md
# Multidrop UART with Station Address Filter

This block is a full-duplex asynchronous serial transceiver for shared-line networks in which many stations listen on one pair of wires. A host writes bytes to send through a single-cycle write strobe and collects received bytes through a single-cycle read strobe. Each direction has one holding register in front of its shift register. The host can therefore queue the next byte while the current one is on the line, and a received byte waits in the holding register while the next frame is being assembled.

The frame format is set by static inputs: the word length (5 to 8 bits), the parity (none, even or odd), the stop length (one or two bits) and the bit rate, which comes from a divisor applied to the system clock. A ninth-bit mode adds a flag to each frame that marks it as an address. In that mode the receiver holds a station address and discards data traffic until a frame naming this station arrives.

The receiver oversamples the line sixteen times per bit. A start bit counts only if the line is still low at its centre. Every later bit is taken at its centre. A frame error, a parity error and an overrun are each reported beside the held byte.

Top module: `mdrop_uart`

## Requirements
- R1: While reset is low, and in the first cycle after it, `txd` is 1, `txHoldEmpty` is 1, `txIdle` is 1, and `rxReady` and `rxOverrun` are 0.
- R2: An oversample tick occurs once every `cfgDivisor`+1 clock cycles, and every bit on `txd` lasts 16 ticks. A transmitted frame is one low start bit, then N = 5 + `cfgDataBits` data bits with the least significant bit first, then high stop bits: one when `cfgTwoStop` = 0 and two when it is 1. The line is high when idle.
- R3: `cfgParity` = 1 selects even parity, 2 selects odd parity, and 0 or 3 sends no parity bit. The parity bit follows the data bits and the address flag. It covers the N data bits and, in ninth-bit mode, the flag bit. With even parity the count of ones is even; with odd parity it is odd.
- R4: A write (`txWrEn` high) is taken only while `txHoldEmpty` is 1. A write while the holding register is full is dropped and changes nothing on the line. When a byte is waiting, its start bit follows the last stop bit of the previous frame with no idle gap.
- R5: `txHoldEmpty` is 1 whenever the holding register has no byte waiting. `txIdle` is 1 only when no frame is being shifted out.
- R6: A received frame sets `rxReady`. `rxRdData` then holds the N data bits, aligned to bit 0, with all higher bits 0. A one-cycle `rxRdEn` clears `rxReady`.
- R7: `rxFrameErr` is 1 for a held byte whose first stop bit was sampled low. The receiver examines only the first stop bit.
- R8: `rxParityErr` is 1 for a held byte whose received parity bit does not match the parity selected by `cfgParity`. It is always 0 when parity is off.
- R9: When a frame completes while `rxReady` is 1 and no read happens in that cycle, `rxOverrun` becomes 1 and the held byte is left unchanged. `rxRdEn` clears `rxOverrun`.
- R10: When `cfgNineBit` = 1, the transmitter sends `txWrAddr` as an extra bit after the data bits and before the parity bit.
- R11: When `cfgNineBit` = 1, a received frame whose flag is 1 is compared with `cfgStationAddr`, with its data zero-extended to 8 bits. On a match, the frame is delivered with `rxRdAddr` = 1 and later data frames (flag 0) are delivered. On a mismatch, the frame is dropped and later data frames are dropped until a matching address arrives. After reset, data frames are dropped. When `cfgNineBit` = 0, every frame is delivered and `rxRdAddr` is 0.
- R12: A low pulse on `rxd` that ends before the middle of a bit period does not start a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDivisor | input | 16 | Clock cycles per oversample tick, minus one |
| cfgDataBits | input | 2 | Word length minus 5 |
| cfgParity | input | 2 | 0 or 3 none, 1 even, 2 odd |
| cfgTwoStop | input | 1 | Send two stop bits |
| cfgNineBit | input | 1 | Enable the address flag bit and the filter |
| cfgStationAddr | input | 8 | Address of this station |
| txWrEn | input | 1 | Write strobe for the transmit holding register |
| txWrData | input | 8 | Byte to send |
| txWrAddr | input | 1 | Flag bit sent with the byte in ninth-bit mode |
| txHoldEmpty | output | 1 | Transmit holding register can take a byte |
| txIdle | output | 1 | Transmit shifter is not sending a frame |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input, asynchronous |
| rxRdEn | input | 1 | Read strobe, frees the receive holding register |
| rxRdData | output | 8 | Received byte |
| rxRdAddr | output | 1 | Received byte was an address frame |
| rxReady | output | 1 | A received byte is waiting |
| rxFrameErr | output | 1 | Held byte had a low stop bit |
| rxParityErr | output | 1 | Held byte had a parity mismatch |
| rxOverrun | output | 1 | A frame was lost because the holding register was full |

## Verification
The assertions assume that the host pulses `txWrEn` and `rxRdEn` for single cycles and that the configuration inputs change only while both directions are quiet. The stimulus respects both assumptions. It changes the frame format and the divisor only after the transmitter reports idle with an empty holding register, and only between received frames. Serial frames are driven on `rxd` at exactly the configured bit period, so every centre sample falls well inside its bit. The one exception is the deliberately short glitch used to test start-bit rejection.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_FLAG, TX_PAR, TX_STOP
  } txPhase_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_FLAG, RX_PAR, RX_STOP
  } rxPhase_t;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic txLoad;   // move holding register into shifter
    logic txShift;  // advance to next data bit
    logic rxClear;  // start bit confirmed, clear assembly
    logic rxBit;    // sample a data bit at rxBitIdx
    logic rxFlag;   // sample the address flag
    logic rxPar;    // sample the parity bit
    logic rxDone;   // sample stop bit and finish the frame
  } strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_BITS   = 5,
  parameter int OVERSAMPLE = 16,
  localparam int SEL_W     = $clog2(DATA_W - MIN_BITS + 1),
  localparam int IDX_W     = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             txHoldFull,
  input  logic             rxLine,
  input  logic [SEL_W-1:0] cfgDataBits,
  input  logic [1:0]       cfgParity,
  input  logic             cfgTwoStop,
  input  logic             cfgNineBit,
  output strobe_t          stb,
  output txPhase_t         txPhase,
  output logic [IDX_W-1:0] rxBitIdx,
  output logic             txIdle
);

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_MAX  = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] HALF_CHK = SUB_W'(OVERSAMPLE / 2 - 1);

  txPhase_t         txState;
  rxPhase_t         rxState;
  logic [SUB_W-1:0] txSub, rxSub;
  logic [IDX_W-1:0] txCnt, rxCnt;

  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] lastStop;
  logic             parOn;
  logic             txBitEnd, rxBitEnd, txFrameEnd;

  assign lastIdx    = IDX_W'(MIN_BITS - 1) + IDX_W'(cfgDataBits);
  assign lastStop   = IDX_W'(cfgTwoStop);
  assign parOn      = (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);
  assign txBitEnd   = tick && (txSub == SUB_MAX);
  assign rxBitEnd   = tick && (rxSub == SUB_MAX);
  assign txFrameEnd = txBitEnd && (txState == TX_STOP) && (txCnt == lastStop);

  // transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSub   <= '0;
      txCnt   <= '0;
    end else if (tick) begin
      if (txState == TX_IDLE) begin
        if (txHoldFull) begin
          txState <= TX_START;
          txSub   <= '0;
        end
      end else begin
        txSub <= (txSub == SUB_MAX) ? '0 : txSub + 1'b1;
        if (txSub == SUB_MAX) begin
          unique case (txState)
            TX_START: begin
              txState <= TX_DATA;
              txCnt   <= '0;
            end
            TX_DATA: begin
              if (txCnt == lastIdx) begin
                txCnt   <= '0;
                txState <= cfgNineBit ? TX_FLAG : (parOn ? TX_PAR : TX_STOP);
              end else begin
                txCnt <= txCnt + 1'b1;
              end
            end
            TX_FLAG: txState <= parOn ? TX_PAR : TX_STOP;
            TX_PAR:  txState <= TX_STOP;
            TX_STOP: begin
              if (txCnt == lastStop) begin
                txCnt   <= '0;
                txState <= txHoldFull ? TX_START : TX_IDLE;
              end else begin
                txCnt <= txCnt + 1'b1;
              end
            end
            default: txState <= TX_IDLE;
          endcase
        end
      end
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxCnt   <= '0;
    end else if (tick) begin
      unique case (rxState)
        RX_IDLE: begin
          if (!rxLine) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
        end
        RX_START: begin
          if (rxSub == HALF_CHK) begin
            rxSub   <= '0;
            rxCnt   <= '0;
            rxState <= rxLine ? RX_IDLE : RX_DATA;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
        default: begin
          rxSub <= (rxSub == SUB_MAX) ? '0 : rxSub + 1'b1;
          if (rxSub == SUB_MAX) begin
            unique case (rxState)
              RX_DATA: begin
                if (rxCnt == lastIdx) begin
                  rxState <= cfgNineBit ? RX_FLAG : (parOn ? RX_PAR : RX_STOP);
                end else begin
                  rxCnt <= rxCnt + 1'b1;
                end
              end
              RX_FLAG: rxState <= parOn ? RX_PAR : RX_STOP;
              RX_PAR:  rxState <= RX_STOP;
              default: rxState <= RX_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.txLoad  = tick && txHoldFull && ((txState == TX_IDLE) || txFrameEnd);
    stb.txShift = txBitEnd && (txState == TX_DATA);
    stb.rxClear = tick && (rxState == RX_START) && (rxSub == HALF_CHK) && !rxLine;
    stb.rxBit   = rxBitEnd && (rxState == RX_DATA);
    stb.rxFlag  = rxBitEnd && (rxState == RX_FLAG);
    stb.rxPar   = rxBitEnd && (rxState == RX_PAR);
    stb.rxDone  = rxBitEnd && (rxState == RX_STOP);
  end

  assign txPhase  = txState;
  assign rxBitIdx = rxCnt;
  assign txIdle   = (txState == TX_IDLE);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MIN_BITS    = 5,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(DATA_W - MIN_BITS + 1),
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic [SEL_W-1:0]  cfgDataBits,
  input  logic [1:0]        cfgParity,
  input  logic              cfgNineBit,
  input  logic [DATA_W-1:0] cfgStationAddr,
  input  strobe_t           stb,
  input  txPhase_t          txPhase,
  input  logic [IDX_W-1:0]  rxBitIdx,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrAddr,
  input  logic              rxRdEn,
  input  logic              rxd,
  output logic              tick,
  output logic              txHoldFull,
  output logic              rxLine,
  output logic              txd,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdAddr,
  output logic              rxReady,
  output logic              rxFrameErr,
  output logic              rxParityErr,
  output logic              rxOverrun
);

  localparam int SPAN = DATA_W - MIN_BITS;

  function automatic logic calcPar(input logic [DATA_W-1:0] d, input logic f,
                                   input logic [1:0] mode);
    logic p;
    p = ^{d, f};
    return (mode == PAR_ODD) ? ~p : p;
  endfunction

  // bit-rate tick
  logic [DIV_W-1:0] divCnt;
  assign tick = (divCnt >= cfgDivisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  logic [DATA_W-1:0] dataMask;
  logic              parOn;
  assign dataMask = {DATA_W{1'b1}} >> (SPAN - int'(cfgDataBits));
  assign parOn    = (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);

  // transmit holding register and shifter
  logic [DATA_W-1:0] txHold, txShiftReg, txHoldMasked;
  logic              txHoldFlag, txFlagReg, txParBit, txFlagEff;

  assign txHoldMasked = txHold & dataMask;
  assign txFlagEff    = txHoldFlag & cfgNineBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= '0;
      txHoldFlag <= 1'b0;
      txHoldFull <= 1'b0;
      txShiftReg <= '0;
      txFlagReg  <= 1'b0;
      txParBit   <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txShiftReg <= txHoldMasked;
        txFlagReg  <= txFlagEff;
        txParBit   <= calcPar(txHoldMasked, txFlagEff, cfgParity);
        txHoldFull <= 1'b0;
      end else if (stb.txShift) begin
        txShiftReg <= txShiftReg >> 1;
      end
      if (txWrEn && !txHoldFull) begin
        txHold     <= txWrData;
        txHoldFlag <= txWrAddr;
        txHoldFull <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (txPhase)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = txShiftReg[0];
      TX_FLAG:  txd = txFlagReg;
      TX_PAR:   txd = txParBit;
      default:  txd = 1'b1;
    endcase
  end

  // receive input synchroniser
  logic [SYNC_STAGES-1:0] syncReg;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= rxd;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate
  assign rxLine = syncReg[SYNC_STAGES-1];

  // receive assembly
  logic [DATA_W-1:0] rxShiftReg;
  logic              rxFlagReg, rxParReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxFlagReg  <= 1'b0;
      rxParReg   <= 1'b0;
    end else if (stb.rxClear) begin
      rxShiftReg <= '0;
      rxFlagReg  <= 1'b0;
      rxParReg   <= 1'b0;
    end else begin
      if (stb.rxBit)  rxShiftReg[rxBitIdx] <= rxLine;
      if (stb.rxFlag) rxFlagReg <= rxLine;
      if (stb.rxPar)  rxParReg  <= rxLine;
    end
  end

  // frame completion, station filter and holding register
  logic accept, keep, addrHit, parBad;
  assign addrHit = (rxShiftReg == cfgStationAddr);
  assign parBad  = parOn && (rxParReg != calcPar(rxShiftReg, rxFlagReg, cfgParity));
  assign keep    = !cfgNineBit || (rxFlagReg ? addrHit : accept);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept      <= 1'b0;
      rxRdData    <= '0;
      rxRdAddr    <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
      rxReady     <= 1'b0;
      rxOverrun   <= 1'b0;
    end else begin
      if (rxRdEn) begin
        rxReady   <= 1'b0;
        rxOverrun <= 1'b0;
      end
      if (stb.rxDone) begin
        if (cfgNineBit && rxFlagReg) accept <= addrHit;
        if (keep) begin
          if (rxReady && !rxRdEn) begin
            rxOverrun <= 1'b1;
          end else begin
            rxRdData    <= rxShiftReg;
            rxRdAddr    <= rxFlagReg;
            rxFrameErr  <= !rxLine;
            rxParityErr <= parBad;
            rxReady     <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MIN_BITS    = 5,
  parameter int DIV_W       = 16,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(DATA_W - MIN_BITS + 1),
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic [SEL_W-1:0]  cfgDataBits,
  input  logic [1:0]        cfgParity,
  input  logic              cfgTwoStop,
  input  logic              cfgNineBit,
  input  logic [DATA_W-1:0] cfgStationAddr,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrAddr,
  output logic              txHoldEmpty,
  output logic              txIdle,
  output logic              txd,
  input  logic              rxd,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdAddr,
  output logic              rxReady,
  output logic              rxFrameErr,
  output logic              rxParityErr,
  output logic              rxOverrun
);

  strobe_t          stb;
  txPhase_t         txPhase;
  logic [IDX_W-1:0] rxBitIdx;
  logic             tick, txHoldFull, rxLine;

  mdu_ctrl #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .txHoldFull(txHoldFull),
    .rxLine(rxLine), .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .cfgNineBit(cfgNineBit), .stb(stb),
    .txPhase(txPhase), .rxBitIdx(rxBitIdx), .txIdle(txIdle)
  );

  mdu_datapath #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgDivisor(cfgDivisor), .cfgDataBits(cfgDataBits),
    .cfgParity(cfgParity), .cfgNineBit(cfgNineBit), .cfgStationAddr(cfgStationAddr),
    .stb(stb), .txPhase(txPhase), .rxBitIdx(rxBitIdx), .txWrEn(txWrEn),
    .txWrData(txWrData), .txWrAddr(txWrAddr), .rxRdEn(rxRdEn), .rxd(rxd),
    .tick(tick), .txHoldFull(txHoldFull), .rxLine(rxLine), .txd(txd),
    .rxRdData(rxRdData), .rxRdAddr(rxRdAddr), .rxReady(rxReady),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxOverrun(rxOverrun)
  );

  assign txHoldEmpty = !txHoldFull;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txWrEn,
  input logic              txHoldEmpty,
  input logic              txIdle,
  input logic              txd,
  input logic              rxRdEn,
  input logic              rxReady,
  input logic              rxOverrun,
  input logic [DATA_W-1:0] rxRdData
);

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txd);

  // R4
  hold_fill_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txHoldEmpty) |-> $past(txWrEn));

  // R6
  ready_clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(rxRdEn));

  // R9
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxReady));

  // R9
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rxRdEn) |=> $stable(rxRdData));

endmodule

bind mdrop_uart mdu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .txHoldEmpty(txHoldEmpty),
  .txIdle(txIdle), .txd(txd), .rxRdEn(rxRdEn), .rxReady(rxReady),
  .rxOverrun(rxOverrun), .rxRdData(rxRdData)
);

// File: tb/mdrop_uart_bench.sv
module mdrop_uart_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgDivisor = 16'd3;
  logic [1:0]  cfgDataBits = 2'd3;
  logic [1:0]  cfgParity = 2'd0;
  logic        cfgTwoStop = 1'b0;
  logic        cfgNineBit = 1'b0;
  logic [7:0]  cfgStationAddr = 8'h5A;
  logic        txWrEn = 1'b0;
  logic [7:0]  txWrData = '0;
  logic        txWrAddr = 1'b0;
  logic        rxd = 1'b1;
  logic        rxRdEn = 1'b0;
  logic        txHoldEmpty, txIdle, txd;
  logic [7:0]  rxRdData;
  logic        rxRdAddr, rxReady, rxFrameErr, rxParityErr, rxOverrun;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string txReq = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdrop_uart u_mdrop_uart (
    .clk(clk), .rstN(rstN), .cfgDivisor(cfgDivisor), .cfgDataBits(cfgDataBits),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop), .cfgNineBit(cfgNineBit),
    .cfgStationAddr(cfgStationAddr), .txWrEn(txWrEn), .txWrData(txWrData),
    .txWrAddr(txWrAddr), .txHoldEmpty(txHoldEmpty), .txIdle(txIdle), .txd(txd),
    .rxd(rxd), .rxRdEn(rxRdEn), .rxRdData(rxRdData), .rxRdAddr(rxRdAddr),
    .rxReady(rxReady), .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .rxOverrun(rxOverrun)
  );

  // ---------------- behavioural transmit reference ----------------
  logic [8:0] mHold[$];
  bit         mBits[$];
  int         mDiv = 0;
  int         mSub = 0;
  bit         mWasFull, mTick;

  function automatic bit parOf(input logic [7:0] d, input bit f, input logic [1:0] mode);
    bit p = ^{d, f};
    return (mode == 2'd2) ? !p : p;
  endfunction

  task automatic buildFrame(input logic [8:0] w);
    int n = 5 + int'(cfgDataBits);
    logic [7:0] d = w[7:0] & 8'((1 << n) - 1);
    bit f = w[8] & cfgNineBit;
    mBits.push_back(1'b0);
    for (int i = 0; i < n; i++) mBits.push_back(d[i]);
    if (cfgNineBit) mBits.push_back(f);
    if (cfgParity == 2'd1 || cfgParity == 2'd2) mBits.push_back(parOf(d, f, cfgParity));
    mBits.push_back(1'b1);
    if (cfgTwoStop) mBits.push_back(1'b1);
    mSub = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHold.delete();
      mBits.delete();
      mDiv = 0;
      mSub = 0;
    end else begin
      mWasFull = (mHold.size() != 0);
      mTick = (mDiv >= int'(cfgDivisor));
      mDiv = mTick ? 0 : mDiv + 1;
      if (mTick) begin
        if (mBits.size() != 0) begin
          if (mSub == 15) begin
            mSub = 0;
            void'(mBits.pop_front());
            if (mBits.size() == 0 && mWasFull) buildFrame(mHold.pop_front());
          end else begin
            mSub++;
          end
        end else if (mWasFull) begin
          buildFrame(mHold.pop_front());
        end
      end
      if (txWrEn && !mWasFull) mHold.push_back({txWrAddr, txWrData});
    end
  end

  // compare the transmit side on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit eTxd, eEmpty, eIdle;
      eTxd   = (mBits.size() != 0) ? mBits[0] : 1'b1;
      eEmpty = (mHold.size() == 0);
      eIdle  = (mBits.size() == 0);
      vectors++;
      if (txd !== eTxd || txHoldEmpty !== eEmpty || txIdle !== eIdle) begin
        fails++;
        $display("FAIL %s tx compare t=%0t: txd/empty/idle actual %b%b%b expected %b%b%b",
                 txReq, $time, txd, txHoldEmpty, txIdle, eTxd, eEmpty, eIdle);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] d, input bit f);
    txWrEn = 1'b1; txWrData = d; txWrAddr = f;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic waitTxDone();
    do @(negedge clk); while (!(txIdle && txHoldEmpty && mBits.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  task automatic hostRead();
    rxRdEn = 1'b1;
    @(negedge clk);
    rxRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic driveBit(input bit v);
    rxd = v;
    repeat (16 * (int'(cfgDivisor) + 1)) @(negedge clk);
  endtask

  task automatic rxSend(input logic [7:0] d, input bit f, input bit badPar, input bit badStop);
    int n = 5 + int'(cfgDataBits);
    logic [7:0] m = d & 8'((1 << n) - 1);
    driveBit(1'b0);
    for (int i = 0; i < n; i++) driveBit(m[i]);
    if (cfgNineBit) driveBit(f);
    if (cfgParity == 2'd1 || cfgParity == 2'd2)
      driveBit(parOf(m, f & cfgNineBit, cfgParity) ^ badPar);
    driveBit(!badStop);
    if (cfgTwoStop) driveBit(1'b1);
    driveBit(1'b1);
  endtask

  task automatic checkRx(input string req, input bit eReady, input logic [7:0] eData,
                         input bit eAddr, input bit eFe, input bit ePe, input bit eOv);
    check(rxReady === eReady, req, "rxReady", int'(rxReady), int'(eReady));
    check(rxOverrun === eOv, req, "rxOverrun", int'(rxOverrun), int'(eOv));
    if (eReady) begin
      check(rxRdData === eData, req, "rxRdData", int'(rxRdData), int'(eData));
      check(rxRdAddr === eAddr, req, "rxRdAddr", int'(rxRdAddr), int'(eAddr));
      check(rxFrameErr === eFe, req, "rxFrameErr", int'(rxFrameErr), int'(eFe));
      check(rxParityErr === ePe, req, "rxParityErr", int'(rxParityErr), int'(ePe));
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    check(txd === 1'b1 && txHoldEmpty === 1'b1 && txIdle === 1'b1, "R1", "tx reset",
          {txd, txHoldEmpty, txIdle}, 3'b111);
    check(rxReady === 1'b0 && rxOverrun === 1'b0, "R1", "rx reset", {rxReady, rxOverrun}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxReady === 1'b0, "R1", "rxReady after release", int'(rxReady), 0);
    repeat (5) @(negedge clk);

    // R2 R4: 8N1, second byte queued while the first shifts, third write dropped
    txReq = "R2 R4";
    hostWrite(8'hA5, 1'b0);
    do @(negedge clk); while (!txHoldEmpty);
    hostWrite(8'h3C, 1'b0);
    hostWrite(8'hFF, 1'b0);
    check(txHoldEmpty === 1'b0, "R4", "hold full after queue", int'(txHoldEmpty), 0);
    check(txIdle === 1'b0, "R5", "shifter busy", int'(txIdle), 0);
    waitTxDone();
    check(txIdle === 1'b1 && txHoldEmpty === 1'b1, "R5", "idle after drain",
          {txIdle, txHoldEmpty}, 2'b11);

    // R3: 5 bits, even parity, two stops
    txReq = "R3 R2";
    cfgDataBits = 2'd0; cfgParity = 2'd1; cfgTwoStop = 1'b1;
    hostWrite(8'hF3, 1'b0);
    waitTxDone();

    // R3: 7 bits, odd parity, fastest divisor
    txReq = "R3";
    cfgDataBits = 2'd2; cfgParity = 2'd2; cfgTwoStop = 1'b0; cfgDivisor = 16'd0;
    hostWrite(8'h55, 1'b0);
    waitTxDone();

    // R10: ninth-bit mode, address then data back to back
    txReq = "R10";
    cfgDataBits = 2'd3; cfgParity = 2'd1; cfgNineBit = 1'b1; cfgDivisor = 16'd3;
    hostWrite(8'h5A, 1'b1);
    do @(negedge clk); while (!txHoldEmpty);
    hostWrite(8'h0F, 1'b0);
    waitTxDone();

    cfgParity = 2'd0; cfgNineBit = 1'b0;
    txReq = "R2";

    // R6: plain receive
    rxSend(8'h96, 1'b0, 1'b0, 1'b0);
    checkRx("R6", 1'b1, 8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
    hostRead();
    checkRx("R6", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6 R8: 6 bits even parity, good then bad
    cfgDataBits = 2'd1; cfgParity = 2'd1;
    rxSend(8'hEB, 1'b0, 1'b0, 1'b0);
    checkRx("R6", 1'b1, 8'h2B, 1'b0, 1'b0, 1'b0, 1'b0);
    hostRead();
    rxSend(8'h2B, 1'b0, 1'b1, 1'b0);
    checkRx("R8", 1'b1, 8'h2B, 1'b0, 1'b0, 1'b1, 1'b0);
    hostRead();

    // R7: low stop bit
    cfgDataBits = 2'd3; cfgParity = 2'd0;
    rxSend(8'h81, 1'b0, 1'b0, 1'b1);
    checkRx("R7", 1'b1, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0);
    hostRead();
    driveBit(1'b1);

    // R9: overrun keeps first byte, read clears
    rxSend(8'h11, 1'b0, 1'b0, 1'b0);
    rxSend(8'h22, 1'b0, 1'b0, 1'b0);
    checkRx("R9", 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    hostRead();
    checkRx("R9", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R12: short glitch ignored, then a real frame still works
    rxd = 1'b0;
    repeat (4 * (int'(cfgDivisor) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (12) driveBit(1'b1);
    checkRx("R12", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rxSend(8'h7E, 1'b0, 1'b0, 1'b0);
    checkRx("R12", 1'b1, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0);
    hostRead();

    // R11: station filter
    cfgNineBit = 1'b1;
    rxSend(8'h11, 1'b0, 1'b0, 1'b0);
    checkRx("R11", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rxSend(8'h33, 1'b1, 1'b0, 1'b0);
    checkRx("R11", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rxSend(8'h5A, 1'b1, 1'b0, 1'b0);
    checkRx("R11", 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
    hostRead();
    rxSend(8'h77, 1'b0, 1'b0, 1'b0);
    checkRx("R11", 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    hostRead();
    rxSend(8'h12, 1'b1, 1'b0, 1'b0);
    checkRx("R11", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rxSend(8'h44, 1'b0, 1'b0, 1'b0);
    checkRx("R11", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule